// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block sits between an interrupt priority resolver and the CPU bus of an interrupt controller. When the resolver has flagged a winning request line, the CPU answers with a series of acknowledge pulses. The sequencer counts those pulses and moves the winning line from the pending register into the in-service register on the first pulse. It then supplies the data byte expected for every pulse.

Two bus modes are supported. In the three-pulse mode the block returns a CALL opcode, then the low byte and then the high byte of a service-routine address. The low byte combines upper bits of the first initialization word with the line number scaled by a four-byte vector spacing. The high byte is the second initialization word. In the two-pulse mode the first pulse returns no data, and the second returns an 8-bit vector number built from the second initialization word and the line number.

With automatic end-of-interrupt enabled, the in-service bit is released when the last pulse ends. Otherwise it is released by an explicit end-of-interrupt strobe. Pending bits are captured on rising edges of the request lines.

Top module: `intack_seq`

## Requirements
- R1: Synchronous active-low reset clears pend_q, isr_q, data_out and data_oe and returns the sequencer to idle.
- R2: A rising edge on req_in[i] sets pend_q[i] at the clock edge that samples the edge.
- R3: An acknowledge rising edge sampled while idle with irq_active high starts a sequence. At that clock edge it sets isr_q[win_idx] and clears pend_q[win_idx].
- R4: With mode_three=1, the three pulses return 0xCD, then {init_word1[7:5], line[2:0], 2'b00}, then init_word2[7:0].
- R5: With mode_three=0, the first pulse returns no data (data_oe stays 0), and the second returns {init_word2[7:3], line[2:0]}.
- R6: data_oe is 1 only between the clock edge that samples a data-returning acknowledge rise and the clock edge that samples its fall. While data_oe is 0, data_out is 0x00.
- R7: The line number and the mode are latched on the first pulse. Changes on win_idx or mode_three later in the sequence do not alter the returned bytes.
- R8: With auto_eoi=1 at the trailing edge of the final pulse, the in-service bit of the sequence is cleared at that edge. With auto_eoi=0 it stays set.
- R9: A one-cycle eoi_cmd clears isr_q[eoi_line].
- R10: An acknowledge pulse seen while idle with irq_active low is ignored: data_oe stays 0 and pend_q and isr_q are unchanged.
- R11: After the trailing edge of the final pulse of the latched mode (second or third pulse), the sequencer is idle, so the next accepted pulse starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | 8 | Interrupt request lines, rising edge sets pending |
| irq_active | input | 1 | Resolver has raised an interrupt |
| win_idx | input | 3 | Winning line from the resolver |
| ack_in | input | 1 | Acknowledge strobe, high while a pulse is active |
| mode_three | input | 1 | 1 = three-pulse call mode, 0 = two-pulse vector mode |
| auto_eoi | input | 1 | Automatic end-of-interrupt enable |
| init_word1 | input | 8 | First initialization word |
| init_word2 | input | 8 | Second initialization word |
| eoi_cmd | input | 1 | End-of-interrupt strobe |
| eoi_line | input | 3 | Line released by eoi_cmd |
| data_out | output | 8 | Byte returned to the bus |
| data_oe | output | 1 | Bus drive enable (stands for the tri-state control) |
| pend_q | output | 8 | Pending register |
| isr_q | output | 8 | In-service register |

## Verification
The assertions assume that acknowledge pulses are at least one clock high and one clock low. They also assume that irq_active and win_idx are stable at the clock edge that samples the first rise, and that a request edge and an end-of-interrupt never target the line taken by a first pulse in that same cycle. The stimulus changes every input at the falling clock edge and holds each acknowledge level for a full clock. It raises request lines and issues end-of-interrupt strobes only between sequences. Deliberate mid-sequence changes are confined to win_idx, mode_three and irq_active, whose effect must be nil.

// File: rtl/intack_pkg.sv
// Package: shared constants and the pulse-phase type of the acknowledge sequencer.
// Assumes an 8-bit data bus.
package intack_pkg;
    localparam int          BYTE_W      = 8;
    localparam logic [7:0]  CALL_OPCODE = 8'hCD;

    // Number of acknowledge rises already accepted in the current sequence.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ONE   = 2'd1,
        PH_TWO   = 2'd2,
        PH_THREE = 2'd3
    } phase_e;
endpackage

// File: rtl/ack_edge_detect.sv
// Module: ack_edge_detect
// Registers a bundle of level inputs and flags rising and falling edges one
// sample after they occur. Assumes the inputs are already synchronous to clk.
module ack_edge_detect #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_in,
    output logic [W-1:0] sig_q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    // Sample register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_in;
    end

    // Edge flags from the current input against the last sample.
    always_comb begin
        rise = sig_in & ~sig_q;
        fall = ~sig_in & sig_q;
    end
endmodule

// File: rtl/ack_phase_ctrl.sv
// Module: ack_phase_ctrl
// Counts acknowledge pulses, latches the winning line and the bus mode on the
// first pulse and returns to idle after the final pulse of that mode.
// Assumes rise and fall come from ack_edge_detect, so they never coincide.
module ack_phase_ctrl
    import intack_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             fall,
    input  logic             irq_active,
    input  logic [IDX_W-1:0] win_idx,
    input  logic             mode_three,
    output phase_e           phase_q,
    output phase_e           rise_num,
    output logic             first_take,
    output logic             take,
    output logic             last_fall,
    output logic [IDX_W-1:0] idx_eff,
    output logic             mode_eff,
    output logic [IDX_W-1:0] idx_q
);
    logic   mode_q;
    phase_e last_num;
    logic   more_take;

    // Decide which edges are accepted and which line/mode apply to this pulse.
    always_comb begin
        last_num   = mode_q ? PH_THREE : PH_TWO;
        first_take = rise && (phase_q == PH_IDLE) && irq_active;
        more_take  = rise && (phase_q != PH_IDLE) && (phase_q != last_num);
        take       = first_take || more_take;
        last_fall  = fall && (phase_q != PH_IDLE) && (phase_q == last_num);
        rise_num   = phase_q;
        idx_eff    = first_take ? win_idx    : idx_q;
        mode_eff   = first_take ? mode_three : mode_q;
    end

    // Pulse counter with line and mode latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            mode_q  <= 1'b0;
        end else begin
            if (first_take) begin
                idx_q  <= win_idx;
                mode_q <= mode_three;
            end
            if (take)
                phase_q <= phase_e'(phase_q + 2'd1);
            else if (last_fall)
                phase_q <= PH_IDLE;
        end
    end

    AST_TWO_MODE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_THREE) |-> mode_q);  // R11
    AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last_fall |=> (phase_q == PH_IDLE));  // R11
    AST_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |=> (idx_q == $past(idx_q)));  // R7
endmodule

// File: rtl/ack_byte_mux.sv
// Module: ack_byte_mux
// Forms the byte returned for a given pulse number and mode, and says whether
// that pulse returns data at all. Purely combinational.
// Assumes IDX_W + VEC_SHIFT < BYTE_W.
module ack_byte_mux
    import intack_pkg::*;
#(
    parameter int IDX_W     = 3,
    parameter int VEC_SHIFT = 2
) (
    input  phase_e             rise_num,
    input  logic               mode_three,
    input  logic [IDX_W-1:0]   line,
    input  logic [BYTE_W-1:0]  init_word1,
    input  logic [BYTE_W-1:0]  init_word2,
    output logic [BYTE_W-1:0]  byte_val,
    output logic               has_data
);
    localparam int LOW_KEEP = BYTE_W - IDX_W - VEC_SHIFT;

    logic [BYTE_W-1:0] addr_low;
    logic [BYTE_W-1:0] vec_num;

    // Address low byte: kept upper bits, line number, vector spacing.
    always_comb begin
        addr_low = {init_word1[BYTE_W-1 -: LOW_KEEP], line, {VEC_SHIFT{1'b0}}};
        vec_num  = {init_word2[BYTE_W-1:IDX_W], line};
    end

    // Per-pulse byte selection for both bus modes.
    always_comb begin
        byte_val = '0;
        has_data = 1'b0;
        if (mode_three) begin
            has_data = 1'b1;
            case (rise_num)
                PH_IDLE: byte_val = CALL_OPCODE;
                PH_ONE:  byte_val = addr_low;
                PH_TWO:  byte_val = init_word2;
                default: has_data = 1'b0;
            endcase
        end else if (rise_num == PH_ONE) begin
            has_data = 1'b1;
            byte_val = vec_num;
        end
    end
endmodule

// File: rtl/irq_state_regs.sv
// Module: irq_state_regs
// Holds the pending and in-service registers. Pending bits set on request
// edges and clear when taken. In-service bits set when taken and clear on an
// automatic or explicit end-of-interrupt.
// Assumes at most one take and one of each clear per cycle.
module irq_state_regs #(
    parameter int N_LINES = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_rise,
    input  logic               take_en,
    input  logic [IDX_W-1:0]   take_idx,
    input  logic               aeoi_en,
    input  logic [IDX_W-1:0]   aeoi_idx,
    input  logic               eoi_en,
    input  logic [IDX_W-1:0]   eoi_idx,
    output logic [N_LINES-1:0] pend_q,
    output logic [N_LINES-1:0] isr_q
);
    logic [N_LINES-1:0] take_mask, aeoi_mask, eoi_mask;

    // One-hot decode of each update request.
    always_comb begin
        take_mask = '0;
        aeoi_mask = '0;
        eoi_mask  = '0;
        for (int i = 0; i < N_LINES; i++) begin
            take_mask[i] = take_en && (take_idx == IDX_W'(i));
            aeoi_mask[i] = aeoi_en && (aeoi_idx == IDX_W'(i));
            eoi_mask[i]  = eoi_en  && (eoi_idx  == IDX_W'(i));
        end
    end

    // Register update per line: clears first, then sets.
    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q[g] <= 1'b0;
                    isr_q[g]  <= 1'b0;
                end else begin
                    pend_q[g] <= (pend_q[g] & ~take_mask[g]) | req_rise[g];
                    isr_q[g]  <= (isr_q[g] & ~aeoi_mask[g] & ~eoi_mask[g]) | take_mask[g];
                end
            end
        end
    endgenerate

    AST_ISR_SET_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take_en |=> ((isr_q & $past(take_mask)) == $past(take_mask)));  // R3
    AST_PEND_CLR_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_en && ((req_rise & take_mask) == '0)) |=> ((pend_q & $past(take_mask)) == '0));  // R3
    AST_AEOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (aeoi_en && ((take_mask & aeoi_mask) == '0)) |=> ((isr_q & $past(aeoi_mask)) == '0));  // R8
    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_en && ((take_mask & eoi_mask) == '0)) |=> ((isr_q & $past(eoi_mask)) == '0));  // R9
endmodule

// File: rtl/intack_seq.sv
// Module: intack_seq (top)
// Acknowledge-pulse sequencer of an interrupt controller: detects acknowledge
// edges, steps through the pulses of the selected bus mode, updates pending and
// in-service registers and registers the byte and drive enable for each pulse.
// Assumes all inputs are synchronous to clk and pulses span whole clocks.
module intack_seq
    import intack_pkg::*;
#(
    parameter int N_LINES   = 8,
    parameter int VEC_SHIFT = 2,
    localparam int IDX_W    = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_in,
    input  logic               irq_active,
    input  logic [IDX_W-1:0]   win_idx,
    input  logic               ack_in,
    input  logic               mode_three,
    input  logic               auto_eoi,
    input  logic [BYTE_W-1:0]  init_word1,
    input  logic [BYTE_W-1:0]  init_word2,
    input  logic               eoi_cmd,
    input  logic [IDX_W-1:0]   eoi_line,
    output logic [BYTE_W-1:0]  data_out,
    output logic               data_oe,
    output logic [N_LINES-1:0] pend_q,
    output logic [N_LINES-1:0] isr_q
);
    logic               ack_q, ack_rise, ack_fall;
    logic [N_LINES-1:0] req_q, req_rise, req_fall;
    phase_e             phase_q, rise_num;
    logic               first_take, take, last_fall, mode_eff;
    logic [IDX_W-1:0]   idx_eff, idx_q;
    logic [BYTE_W-1:0]  byte_val;
    logic               has_data;

    ack_edge_detect #(.W(1)) u_ack_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(ack_in),
        .sig_q(ack_q), .rise(ack_rise), .fall(ack_fall)
    );

    ack_edge_detect #(.W(N_LINES)) u_req_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(req_in),
        .sig_q(req_q), .rise(req_rise), .fall(req_fall)
    );

    ack_phase_ctrl #(.IDX_W(IDX_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .rise(ack_rise), .fall(ack_fall),
        .irq_active(irq_active), .win_idx(win_idx), .mode_three(mode_three),
        .phase_q(phase_q), .rise_num(rise_num), .first_take(first_take),
        .take(take), .last_fall(last_fall), .idx_eff(idx_eff),
        .mode_eff(mode_eff), .idx_q(idx_q)
    );

    ack_byte_mux #(.IDX_W(IDX_W), .VEC_SHIFT(VEC_SHIFT)) u_mux (
        .rise_num(rise_num), .mode_three(mode_eff), .line(idx_eff),
        .init_word1(init_word1), .init_word2(init_word2),
        .byte_val(byte_val), .has_data(has_data)
    );

    irq_state_regs #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .req_rise(req_rise),
        .take_en(first_take), .take_idx(win_idx),
        .aeoi_en(last_fall && auto_eoi), .aeoi_idx(idx_q),
        .eoi_en(eoi_cmd), .eoi_idx(eoi_line),
        .pend_q(pend_q), .isr_q(isr_q)
    );

    // Bus output register: load on an accepted rise, drop on any fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
            data_oe  <= 1'b0;
        end else if (take) begin
            data_out <= has_data ? byte_val : '0;
            data_oe  <= has_data;
        end else if (ack_fall) begin
            data_out <= '0;
            data_oe  <= 1'b0;
        end
    end

    AST_OE_INSIDE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> ack_q);  // R6
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_out == '0));  // R6
    AST_CALL_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (first_take && mode_three) |=> (data_oe && data_out == CALL_OPCODE));  // R4
    AST_TWO_FIRST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (first_take && !mode_three) |=> !data_oe);  // R5
    AST_IDLE_PULSE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rise && phase_q == PH_IDLE && !irq_active) |=> (!data_oe && phase_q == PH_IDLE));  // R10
endmodule

// File: tb/sim_intack_seq.sv
// Bench for intack_seq: a vector table walked by one loop, then directed tests.
module sim_intack_seq;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req_in;
    logic       irq_active;
    logic [2:0] win_idx;
    logic       ack_in;
    logic       mode_three;
    logic       auto_eoi;
    logic [7:0] init_word1, init_word2;
    logic       eoi_cmd;
    logic [2:0] eoi_line;
    logic [7:0] data_out;
    logic       data_oe;
    logic [7:0] pend_q, isr_q;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    intack_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .irq_active(irq_active),
        .win_idx(win_idx), .ack_in(ack_in), .mode_three(mode_three),
        .auto_eoi(auto_eoi), .init_word1(init_word1), .init_word2(init_word2),
        .eoi_cmd(eoi_cmd), .eoi_line(eoi_line), .data_out(data_out),
        .data_oe(data_oe), .pend_q(pend_q), .isr_q(isr_q)
    );

    // {mode_three, auto_eoi, line[2:0], word1, word2, byte0, byte1, byte2}
    localparam int NV = 6;
    localparam logic [44:0] VECS [NV] = '{
        {1'b1, 1'b0, 3'd3, 8'hA0, 8'h12, 8'hCD, 8'hAC, 8'h12},
        {1'b1, 1'b1, 3'd7, 8'hE0, 8'h5A, 8'hCD, 8'hFC, 8'h5A},
        {1'b1, 1'b1, 3'd0, 8'h1F, 8'hFF, 8'hCD, 8'h00, 8'hFF},
        {1'b0, 1'b0, 3'd5, 8'h00, 8'h48, 8'h00, 8'h4D, 8'h00},
        {1'b0, 1'b1, 3'd2, 8'h00, 8'hFF, 8'h00, 8'hFA, 8'h00},
        {1'b0, 1'b0, 3'd6, 8'h00, 8'h07, 8'h00, 8'h06, 8'h00}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One acknowledge pulse: high for one clock, low for one clock.
    task automatic pulse(output logic oe_s, output logic [7:0] d_s);
        ack_in = 1'b1;
        @(negedge clk);
        oe_s = data_oe;
        d_s  = data_out;
        ack_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic       oe_s;
        logic [7:0] d_s;
        rst_n = 1'b0; req_in = '0; irq_active = 1'b0; win_idx = '0; ack_in = 1'b0;
        mode_three = 1'b0; auto_eoi = 1'b0; init_word1 = '0; init_word2 = '0;
        eoi_cmd = 1'b0; eoi_line = '0;
        repeat (3) @(negedge clk);
        check("R1 pend", pend_q, 8'h00);
        check("R1 isr", isr_q, 8'h00);
        check("R1 oe", {7'd0, data_oe}, 8'h00);
        check("R1 data", data_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic       m3, ae;
            logic [2:0] ln;
            {m3, ae, ln} = VECS[v][44:40];
            init_word1 = VECS[v][39:32];
            init_word2 = VECS[v][31:24];
            mode_three = m3;
            auto_eoi   = ae;
            req_in[ln] = 1'b1;
            @(negedge clk);
            check("R2 pend set", {7'd0, pend_q[ln]}, 8'h01);
            irq_active = 1'b1;
            win_idx    = ln;
            pulse(oe_s, d_s);
            check("R5/R4 first oe", {7'd0, oe_s}, {7'd0, m3});
            if (m3) check("R4 byte0", d_s, VECS[v][23:16]);
            else    check("R6 silent data", d_s, 8'h00);
            check("R3 isr set", {7'd0, isr_q[ln]}, 8'h01);
            check("R3 pend clr", {7'd0, pend_q[ln]}, 8'h00);
            // R7: disturb the resolver and mode inputs mid-sequence
            win_idx    = ln ^ 3'b101;
            mode_three = ~m3;
            irq_active = 1'b0;
            pulse(oe_s, d_s);
            check("R6 oe pulse2", {7'd0, oe_s}, 8'h01);
            check("R7 R4/R5 byte1", d_s, VECS[v][15:8]);
            check("R6 oe after fall", {7'd0, data_oe}, 8'h00);
            if (m3) begin
                pulse(oe_s, d_s);
                check("R4 byte2", d_s, VECS[v][7:0]);
            end
            check("R8 isr after last", {7'd0, isr_q[ln]}, {7'd0, ~ae});
            if (!ae) begin
                eoi_cmd = 1'b1; eoi_line = ln;
                @(negedge clk);
                eoi_cmd = 1'b0;
                check("R9 eoi clears", {7'd0, isr_q[ln]}, 8'h00);
            end
            req_in[ln] = 1'b0;
            @(negedge clk);
        end

        // R10: stray pulse while idle with no interrupt raised
        req_in[1] = 1'b1;
        @(negedge clk);
        irq_active = 1'b0;
        pulse(oe_s, d_s);
        check("R10 oe", {7'd0, oe_s}, 8'h00);
        check("R10 pend kept", pend_q, 8'h02);
        check("R10 isr kept", isr_q, 8'h00);

        // R11: two-pulse sequence, then an extra pulse, then a new three-pulse start
        mode_three = 1'b0; auto_eoi = 1'b1; init_word2 = 8'h80;
        irq_active = 1'b1; win_idx = 3'd1;
        pulse(oe_s, d_s);
        irq_active = 1'b0;
        pulse(oe_s, d_s);
        check("R11 vector", d_s, 8'h81);
        pulse(oe_s, d_s);
        check("R11 extra ignored", {7'd0, oe_s}, 8'h00);
        mode_three = 1'b1; irq_active = 1'b1; win_idx = 3'd4;
        pulse(oe_s, d_s);
        check("R11 new start", d_s, 8'hCD);

        // R1: reset in the middle of a sequence
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid isr", isr_q, 8'h00);
        check("R1 mid oe", {7'd0, data_oe}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        pulse(oe_s, d_s);
        check("R1 R11 restart", d_s, 8'hCD);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule